// File: doc/BRIEF.md
# ARINC 429 Transmit Serializer

This block takes 32-bit words from a transmit queue through a valid/ready handshake and sends each one serially as a return-to-zero, three-level code on a pair of digital lines. The lines feed an external line driver. Every bit time starts with a data half, where the lines show a ONE or a ZERO, and ends with a NULL half. After the last bit of a word, the lines stay NULL for a word gap of four bit times. Two rates are available: a fast rate of 10 master clocks per bit and a slow rate of 80.

The host chooses whether the last bit of each word is passed through unchanged or replaced by a parity bit, and selects odd or even parity. The enable input decides whether a new word may start. A word that has already started always finishes, gap included. The test input holds both lines at NULL without changing the internal timing. The drained flag is high when no word is in flight and the queue offers nothing more.

Top module: `a429_tx_serializer`

## Requirements
- R1: While reset is asserted, and directly after it, both lines are low. `in_ready` equals `tx_enable`, and `drained` is high when `in_valid` is low.
- R2: A word is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no word is being sent or gapped and `tx_enable` is high.
- R3: Bits are sent least significant first: `in_data[0]` goes first and `in_data[31]` last. A ONE drives `line_a` high and `line_b` low, a ZERO drives `line_a` low and `line_b` high, and a NULL drives both lines low.
- R4: One bit time lasts 10 clocks when `slow_mode` is 0 and 80 clocks when it is 1. The first half carries data and the second half is NULL. The rate is latched when a word is accepted and holds for that whole word.
- R5: After the last bit, the lines stay NULL for 4 bit times (40 or 80x4 = 320 clocks). Only after that can the next word be accepted.
- R6: When `par_en` is 1, the last bit sent is replaced by a parity bit computed over the first 31 bits. The result makes the total count of ones odd when `par_even` is 0 and even when `par_even` is 1. Both settings are sampled when the word is accepted.
- R7: When `par_en` is 0, all 32 bits are sent exactly as they were accepted.
- R8: The data half of the first bit appears on the lines in the clock cycle right after the accepting edge. This is far inside the 2.5 bit-time limit.
- R9: `drained` is high exactly when no word is being sent or gapped and `in_valid` is low. It is low from the cycle after an acceptance until that word's gap has ended.
- R10: While `force_null` is high, both lines are low. Bit and gap timing keep running, and the data half reappears as soon as `force_null` falls.
- R11: If `tx_enable` falls during a word, that word and its gap still complete. No further word is accepted while `tx_enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_mode | input | 1 | 0: 10 clocks per bit, 1: 80 clocks per bit |
| par_en | input | 1 | 1: last bit replaced by parity |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| tx_enable | input | 1 | Permits a new word to start |
| force_null | input | 1 | Holds both lines at NULL |
| in_valid | input | 1 | Queue offers a word |
| in_data | input | 32 | Offered word, bit 0 sent first |
| in_ready | output | 1 | Block takes the offered word on this edge |
| line_a | output | 1 | Line A of the three-level code |
| line_b | output | 1 | Line B of the three-level code |
| drained | output | 1 | Nothing in flight and queue empty |

## Verification
The internal state consists of a phase, a bit counter, a tick counter and a shift register. Each of them reaches the lines within one bit time. A wrong tick limit stretches or shrinks a data half or the gap in the very first bit. A wrong bit count or a wrong shift shows up as a misplaced symbol, or as a word that is one bit too long or too short. A stuck phase shows up on `in_ready` and `drained` the cycle after the gap should have ended. Because the bench compares the lines, `in_ready` and `drained` against a symbol-by-symbol queue on every clock, each of these faults is caught in the first cycle where it differs.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BITS = 2'd1,
      PH_GAP  = 2'd2
   } tx_phase_t;
endpackage

// File: rtl/a429_tx_format.sv
module a429_tx_format #(
   parameter int WORD_W     = 32,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic [WORD_W-1:0] raw,
   input  logic              par_en,
   input  logic              par_even,
   output logic [WORD_W-1:0] word
);
   initial begin
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
   end

   generate
      if (HAS_PARITY) begin : g_parity
         logic par_bit;
         // Ones among the first WORD_W-1 bits, flipped for odd sense.
         assign par_bit = (^raw[WORD_W-2:0]) ^ ~par_even;
         assign word    = par_en ? {par_bit, raw[WORD_W-2:0]} : raw;
      end else begin : g_plain
         logic unused_par;
         assign unused_par = par_en ^ par_even;
         assign word       = raw;
      end
   endgenerate
endmodule

// File: rtl/a429_tx_timer.sv
module a429_tx_timer #(
   parameter int HS_DIV   = 10,
   parameter int LS_DIV   = 80,
   parameter int GAP_BITS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic slow,
   input  logic gap,
   output logic null_half,
   output logic period_end
);
   localparam int LS_GAP = LS_DIV * GAP_BITS;
   localparam int HS_GAP = HS_DIV * GAP_BITS;
   localparam int CW     = $clog2(LS_GAP + 1);

   initial begin
      assert (HS_DIV >= 2 && HS_DIV % 2 == 0) else $error("HS_DIV must be even and >= 2");
      assert (LS_DIV >= HS_DIV && LS_DIV % 2 == 0) else $error("LS_DIV must be even and >= HS_DIV");
      assert (GAP_BITS >= 1) else $error("GAP_BITS must be >= 1");
   end

   logic [CW-1:0] tick_q;
   logic [CW-1:0] limit_m1;
   logic [CW-1:0] half;

   always_comb begin
      case ({gap, slow})
         2'b00:   limit_m1 = CW'(HS_DIV - 1);
         2'b01:   limit_m1 = CW'(LS_DIV - 1);
         2'b10:   limit_m1 = CW'(HS_GAP - 1);
         default: limit_m1 = CW'(LS_GAP - 1);
      endcase
      half = slow ? CW'(LS_DIV / 2) : CW'(HS_DIV / 2);
   end

   assign period_end = (tick_q == limit_m1);
   assign null_half  = (tick_q >= half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tick_q <= '0;
      else if (hold || period_end) tick_q <= '0;
      else                         tick_q <= tick_q + 1'b1;
   end

   // R4
   tick_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q <= limit_m1);
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer #(
   parameter int WORD_W     = 32,
   parameter int HS_DIV     = 10,
   parameter int LS_DIV     = 80,
   parameter int GAP_BITS   = 4,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_mode,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              tx_enable,
   input  logic              force_null,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              line_a,
   output logic              line_b,
   output logic              drained
);
   import a429_tx_pkg::*;

   localparam int BW = $clog2(WORD_W);

   tx_phase_t         phase_q;
   logic [WORD_W-1:0] sr_q;
   logic [WORD_W-1:0] fmt_word;
   logic [BW-1:0]     bit_q;
   logic              slow_q;
   logic              accept;
   logic              null_half;
   logic              period_end;
   logic              data_half;

   a429_tx_format #(.WORD_W(WORD_W), .HAS_PARITY(HAS_PARITY)) u_format (
      .raw      (in_data),
      .par_en   (par_en),
      .par_even (par_even),
      .word     (fmt_word)
   );

   a429_tx_timer #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV), .GAP_BITS(GAP_BITS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (phase_q == PH_IDLE),
      .slow       (slow_q),
      .gap        (phase_q == PH_GAP),
      .null_half  (null_half),
      .period_end (period_end)
   );

   assign in_ready = tx_enable && (phase_q == PH_IDLE);
   assign accept   = in_valid && in_ready;
   assign drained  = (phase_q == PH_IDLE) && !in_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sr_q    <= '0;
         bit_q   <= '0;
         slow_q  <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (accept) begin
               phase_q <= PH_BITS;
               sr_q    <= fmt_word;
               bit_q   <= '0;
               slow_q  <= slow_mode;
            end
            PH_BITS: if (period_end) begin
               sr_q <= sr_q >> 1;
               if (bit_q == BW'(WORD_W - 1)) phase_q <= PH_GAP;
               else                          bit_q   <= bit_q + 1'b1;
            end
            PH_GAP: if (period_end) phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign data_half = (phase_q == PH_BITS) && !null_half && !force_null;
   assign line_a    = data_half && sr_q[0];
   assign line_b    = data_half && !sr_q[0];

   // R3
   ab_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_a && line_b));

   // R10
   forced_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_null |-> (!line_a && !line_b));

   // R2
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready);

   // R9
   drained_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !drained);

   // R5
   gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_GAP) |-> (!line_a && !line_b));
endmodule

// File: tb/a429_tx_serializer_tb.sv
`timescale 1ns/1ps
module a429_tx_serializer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_mode = 1'b0, par_en = 1'b0, par_even = 1'b0;
   logic        tx_enable = 1'b1, force_null = 1'b0, in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready, line_a, line_b, drained;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit idle_m = 1'b1;
   int expq[$];

   always #2.5 clk = ~clk;

   a429_tx_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .par_en(par_en),
      .par_even(par_even), .tx_enable(tx_enable), .force_null(force_null),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .line_a(line_a), .line_b(line_b), .drained(drained)
   );

   function automatic string tag_name(input int t);
      case (t)
         3: return "R3 data bit";
         4: return "R4 null half";
         5: return "R5 word gap";
         6: return "R6 parity bit";
         7: return "R7 last data bit";
         8: return "R8 first bit";
         10: return "R10 forced null";
         11: return "R11 enable low";
         default: return "R2 idle";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // Expected symbol per cycle: sym (0 null, 1 one, 2 zero) + 4*tag
   task automatic push_word(input logic [31:0] d);
      logic [31:0] w;
      int bt;
      int tg;
      w = d;
      if (par_en) w[31] = (^d[30:0]) ^ ~par_even;
      bt = slow_mode ? 80 : 10;
      for (int b = 0; b < 32; b++) begin
         tg = (b == 0) ? 8 : (b == 31) ? (par_en ? 6 : 7) : 3;
         for (int t = 0; t < bt/2; t++) expq.push_back((w[b] ? 1 : 2) + 4*tg);
         for (int t = 0; t < bt/2; t++) expq.push_back(0 + 4*4);
      end
      for (int t = 0; t < 4*bt; t++) expq.push_back(0 + 4*5);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         expq.delete();
         idle_m = 1'b1;
      end else begin
         int e;
         int sym;
         int tg;
         bit was_empty;
         if (idle_m && tx_enable && in_valid) push_word(in_data);
         #1;
         was_empty = (expq.size() == 0);
         if (was_empty) begin sym = 0; tg = tx_enable ? 2 : 11; end
         else begin e = expq.pop_front(); sym = e % 4; tg = e / 4; end
         if (force_null) begin sym = 0; tg = 10; end
         check(line_a == (sym == 1), tag_name(tg), line_a, sym == 1);
         check(line_b == (sym == 2), tag_name(tg), line_b, sym == 2);
         check(in_ready == (was_empty && tx_enable), tx_enable ? "R2 in_ready" : "R11 in_ready",
               in_ready, was_empty && tx_enable);
         check(drained == (was_empty && !in_valid), "R9 drained", drained, was_empty && !in_valid);
         idle_m = was_empty;
      end
   end

   task automatic send(input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!drained) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!line_a && !line_b, "R1 lines in reset", {line_a, line_b}, 0);
      check(drained == 1'b1, "R1 drained in reset", drained, 1);
      check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3 R7: fast rate, data in bit 32
      send(32'hA5C3_0F81); wait_idle();
      // R6 odd parity over all zeros
      par_en = 1'b1; par_even = 1'b0;
      send(32'h0000_0000); wait_idle();
      // R6 even parity
      par_even = 1'b1;
      send(32'h7FFF_FFFF); wait_idle();
      // R5 back-to-back words with gap
      par_en = 1'b0;
      send(32'h1234_5678);
      send(32'h8000_0001); wait_idle();

      // R11 enable low holds off a word, then drops mid-word
      tx_enable = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
      repeat (30) @(negedge clk);
      tx_enable = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_data = 32'h0BAD_F00D;
      repeat (50) @(negedge clk);
      tx_enable = 1'b0;
      repeat (400) @(negedge clk);
      tx_enable = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      wait_idle();

      // R10 forced null in mid-word
      send(32'hFFFF_0000);
      repeat (60) @(negedge clk);
      force_null = 1'b1;
      repeat (100) @(negedge clk);
      force_null = 1'b0;
      wait_idle();

      // R4 slow rate, rate change mid-word has no effect
      slow_mode = 1'b1; par_en = 1'b1; par_even = 1'b0;
      send(32'h0F0F_1234);
      repeat (100) @(negedge clk);
      slow_mode = 1'b0;
      wait_idle();
      slow_mode = 1'b1; par_en = 1'b0;
      send(32'hC000_0003); wait_idle();
      slow_mode = 1'b0;

      repeat (10) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired R2 actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule